// File: doc/BRIEF.md
# Bit-Serial Receive Address Filter

This block sits behind the line decoder of a wired Ethernet receiver and sees the frame one bit at a time, in wire order. It finds the alternating preamble and locks onto the start of the destination address when two 1 bits arrive in a row. It then checks the destination address against the station address bit by bit as each bit arrives. It gives its accept or reject verdict on the earliest bit that settles the outcome, so later stages never have to buffer a frame that is not wanted.

Every event happens on a receive-bit strobe, which lasts one cycle. The bit clock keeps running while the line is idle, so strobes with the carrier flag low count idle bit times. After a frame ends, or the carrier drops partway through one, the block waits for a full idle gap before it looks for a preamble again. An accepted frame opens a gate that stays open until the carrier drops. A downstream stage can use that gate to pass the remaining bits on.

Top module: `rxaf_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, `acc_pulse`, `rej_pulse` and `pass_gate` are 0.
- R2: After reset, and after any frame, preamble search is armed only after IDLE_BITS (96) consecutive strobes with `carrier` low. A strobe with `carrier` high restarts the count, and a frame that arrives before the count completes produces no pulse.
- R3: The preamble is any alternating run that starts with a 1, and it may be as short as one 1-then-0 pair (late wake-up). The first two consecutive 1 bits after at least one alternation mark the end of the delimiter, and the next strobe carries address bit 0.
- R4: Two consecutive 0 bits before the delimiter send the block back to preamble search. A following "1,1" with no alternation before it does not start an address.
- R5: For a unicast frame (address bit 0 = 0), wire bit k is compared with `sta_addr[k]`, with `sta_addr[0]` first on the wire. If all 48 bits match, `acc_pulse` is high for exactly one cycle, on the cycle after the strobe of address bit 47.
- R6: For a unicast frame, `rej_pulse` is high for one cycle, on the cycle after the strobe of the first address bit that differs from `sta_addr`. The block then ignores the rest of the frame, with no further pulse and `pass_gate` held at 0.
- R7: A frame whose first address bit (the group flag) is 1 and whose 48 address bits are all 1 (broadcast) is accepted on bit 47 whatever `mcast_en` is.
- R8: A group frame that is not broadcast is accepted on bit 47 when `mcast_en` is 1. When `mcast_en` is 0 it is rejected on its first 0 address bit.
- R9: With `promisc` at 1, every frame that reaches the address phase is accepted on bit 47 and is never rejected.
- R10: `pass_gate` rises together with `acc_pulse` and stays at 1 for the payload bits. It falls on the cycle after the first strobe with `carrier` low.
- R11: If `carrier` is low on a strobe during the address phase, no pulse is issued and the block returns to waiting for the idle gap.
- R12: After an accepted frame, a gap of 95 idle strobes is not enough to re-arm, and the next frame is ignored.
- R13: `acc_pulse` and `rej_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier | input | 1 | Carrier present, sampled on each strobe |
| bit_stb | input | 1 | One-cycle strobe marking a received bit time |
| bit_dat | input | 1 | Received bit, valid with `bit_stb` |
| sta_addr | input | ADDR_BITS | Station address, bit 0 first on the wire |
| promisc | input | 1 | Accept every frame |
| mcast_en | input | 1 | Accept non-broadcast group frames |
| acc_pulse | output | 1 | One-cycle accept verdict |
| rej_pulse | output | 1 | One-cycle reject verdict |
| pass_gate | output | 1 | High while an accepted frame's bits may be passed on |

## Verification
The checks assume that `bit_stb` is high for one cycle at a time and that `carrier` and `promisc` are only meaningful when a strobe samples them. For that reason the carrier-related properties look at `carrier` only together with a strobe. The bench drives every bit as a strobe of one cycle followed by one quiet cycle. It changes `promisc` and `mcast_en` only during the idle gap between frames. Its random frames always leave at least 96 idle bits between frames, so each one is expected to arm. Gaps that are too short appear only in directed cases.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  typedef enum logic [2:0] {
    ST_GAP,   // waiting for the inter-frame idle gap
    ST_HUNT,  // armed, looking for a preamble
    ST_PRE,   // inside the alternating preamble
    ST_ADDR,  // comparing destination address bits
    ST_PASS,  // frame accepted, passing bits on
    ST_DROP   // frame rejected, ignoring bits
  } rx_state_e;
endpackage

// File: rtl/rxaf_gap_timer.sv
module rxaf_gap_timer #(
  parameter int IDLE_BITS = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic in_gap,
  input  logic bit_stb,
  input  logic carrier,
  output logic gap_done
);
  localparam int CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] idle_cnt;

  assign gap_done = in_gap && bit_stb && !carrier && (idle_cnt == CW'(IDLE_BITS - 1));

  // Counts consecutive idle bit times; the idle strobe that ends a frame counts as the first.
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
    end else if (bit_stb) begin
      if (carrier)        idle_cnt <= '0;
      else if (!in_gap)   idle_cnt <= CW'(1);
      else if (gap_done)  idle_cnt <= '0;
      else                idle_cnt <= idle_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rxaf_addr_cmp.sv
module rxaf_addr_cmp #(
  parameter int ADDR_BITS = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 step,
  input  logic                 bit_in,
  input  logic [ADDR_BITS-1:0] sta_addr,
  input  logic                 promisc,
  input  logic                 mcast_en,
  output logic                 hit,
  output logic                 miss
);
  localparam int IW = $clog2(ADDR_BITS);

  logic [IW-1:0] idx;
  logic          grp_q;
  logic          ones_q;
  logic          first_bit;
  logic          last_bit;
  logic          grp_now;
  logic          ones_now;

  assign first_bit = (idx == '0);
  assign last_bit  = (idx == IW'(ADDR_BITS - 1));
  assign grp_now   = first_bit ? bit_in : grp_q;
  assign ones_now  = (first_bit ? 1'b1 : ones_q) & bit_in;

  always_comb begin
    hit  = 1'b0;
    miss = 1'b0;
    if (step) begin
      if (promisc) begin
        hit = last_bit;
      end else if (grp_now) begin
        // a zero rules out broadcast; without multicast that settles it
        miss = !mcast_en && !bit_in;
        hit  = last_bit && (mcast_en || ones_now);
      end else begin
        miss = (bit_in != sta_addr[idx]);
        hit  = last_bit && !miss;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      idx    <= '0;
      grp_q  <= 1'b0;
      ones_q <= 1'b1;
    end else if (step) begin
      idx    <= idx + IW'(1);
      grp_q  <= grp_now;
      ones_q <= ones_now;
    end
  end
endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter #(
  parameter int ADDR_BITS = 48,
  parameter int IDLE_BITS = 96
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 carrier,
  input  logic                 bit_stb,
  input  logic                 bit_dat,
  input  logic [ADDR_BITS-1:0] sta_addr,
  input  logic                 promisc,
  input  logic                 mcast_en,
  output logic                 acc_pulse,
  output logic                 rej_pulse,
  output logic                 pass_gate
);
  import rxaf_pkg::*;

  rx_state_e state, st_n;
  logic      prev_bit;
  logic      alt_seen;
  logic      gap_done;
  logic      hit;
  logic      miss;
  logic      acc_n;
  logic      rej_n;
  logic      addr_step;

  assign addr_step = (state == ST_ADDR) && bit_stb && carrier;

  rxaf_gap_timer #(.IDLE_BITS(IDLE_BITS)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .in_gap   (state == ST_GAP),
    .bit_stb  (bit_stb),
    .carrier  (carrier),
    .gap_done (gap_done)
  );

  rxaf_addr_cmp #(.ADDR_BITS(ADDR_BITS)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .active   (state == ST_ADDR),
    .step     (addr_step),
    .bit_in   (bit_dat),
    .sta_addr (sta_addr),
    .promisc  (promisc),
    .mcast_en (mcast_en),
    .hit      (hit),
    .miss     (miss)
  );

  always_comb begin
    st_n  = state;
    acc_n = 1'b0;
    rej_n = 1'b0;
    case (state)
      ST_GAP:  if (gap_done) st_n = ST_HUNT;
      ST_HUNT: if (bit_stb && carrier && bit_dat) st_n = ST_PRE;
      ST_PRE: begin
        if (bit_stb) begin
          if (!carrier) begin
            st_n = ST_GAP;
          end else if (bit_dat == prev_bit) begin
            if (!bit_dat)      st_n = ST_HUNT;  // alternation broken
            else if (alt_seen) st_n = ST_ADDR;  // two ones: delimiter end
          end
        end
      end
      ST_ADDR: begin
        if (bit_stb) begin
          if (!carrier) begin
            st_n = ST_GAP;
          end else if (hit) begin
            acc_n = 1'b1;
            st_n  = ST_PASS;
          end else if (miss) begin
            rej_n = 1'b1;
            st_n  = ST_DROP;
          end
        end
      end
      ST_PASS, ST_DROP: if (bit_stb && !carrier) st_n = ST_GAP;
      default: st_n = ST_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_GAP;
      prev_bit  <= 1'b0;
      alt_seen  <= 1'b0;
      acc_pulse <= 1'b0;
      rej_pulse <= 1'b0;
      pass_gate <= 1'b0;
    end else begin
      state     <= st_n;
      acc_pulse <= acc_n;
      rej_pulse <= rej_n;
      pass_gate <= (st_n == ST_PASS);
      if (bit_stb) prev_bit <= bit_dat;
      if (state != ST_PRE)
        alt_seen <= 1'b0;
      else if (bit_stb && carrier && (bit_dat != prev_bit))
        alt_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk (
  input logic clk,
  input logic rst,
  input logic carrier,
  input logic bit_stb,
  input logic promisc,
  input logic acc_pulse,
  input logic rej_pulse,
  input logic pass_gate
);
  // R13
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_pulse && rej_pulse));

  // R5
  acc_single_chk: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |=> !acc_pulse);

  // R6
  rej_single_chk: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |=> !rej_pulse);

  // R11
  acc_on_carrier_chk: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |-> $past(bit_stb && carrier));

  // R9
  no_rej_promisc_chk: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |-> !$past(promisc));

  // R10
  gate_opens_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_gate) |-> acc_pulse);

  // R10
  gate_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_gate && bit_stb && !carrier) |=> !pass_gate);

  // R6
  rej_shut_chk: assert property (@(posedge clk) disable iff (rst)
    rej_pulse |-> !pass_gate);
endmodule

bind rxaf_filter rxaf_filter_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .carrier   (carrier),
  .bit_stb   (bit_stb),
  .promisc   (promisc),
  .acc_pulse (acc_pulse),
  .rej_pulse (rej_pulse),
  .pass_gate (pass_gate)
);

// File: tb/rxaf_filter_bench.sv
`timescale 1ns/1ps
module rxaf_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        carrier = 1'b0;
  logic        bit_stb = 1'b0;
  logic        bit_dat = 1'b0;
  logic [47:0] sta_addr = '0;
  logic        promisc = 1'b0;
  logic        mcast_en = 1'b0;
  logic        acc_pulse;
  logic        rej_pulse;
  logic        pass_gate;

  always #10 clk = ~clk;

  rxaf_filter u_rxaf_filter (
    .clk(clk), .rst(rst), .carrier(carrier), .bit_stb(bit_stb), .bit_dat(bit_dat),
    .sta_addr(sta_addr), .promisc(promisc), .mcast_en(mcast_en),
    .acc_pulse(acc_pulse), .rej_pulse(rej_pulse), .pass_gate(pass_gate)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  int  ev_cnt, first_kind, first_idx, cur_idx, both_cnt;
  logic s_acc, s_rej, s_gate;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One bit time: strobe for a cycle, then a quiet cycle; outputs sampled after the strobe edge.
  task automatic bit_(input logic c, input logic d);
    @(negedge clk);
    bit_stb = 1'b1; carrier = c; bit_dat = d;
    @(negedge clk);
    bit_stb = 1'b0;
    s_acc = acc_pulse; s_rej = rej_pulse; s_gate = pass_gate;
    if (s_acc && s_rej) both_cnt++;
    if (s_acc || s_rej) begin
      ev_cnt++;
      if (first_kind == 0) begin
        first_kind = s_acc ? 1 : 2;
        first_idx  = cur_idx;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bit_(1'b0, 1'b0);
  endtask

  function automatic void exp_decide(input logic [47:0] d, input logic [47:0] s,
                                     input logic pr, input logic mc,
                                     output int kind, output int idx);
    kind = 1; idx = 47;
    if (pr) return;
    if (d[0]) begin
      if (d == {48{1'b1}} || mc) return;
      for (int k = 0; k < 48; k++) if (!d[k]) begin kind = 2; idx = k; return; end
    end else begin
      for (int k = 0; k < 48; k++) if (d[k] != s[k]) begin kind = 2; idx = k; return; end
    end
  endfunction

  task automatic send_frame(input int pre_n, input logic [47:0] d, input int paylen,
                            input int gap, input int drop_at, input bit armed, input string req);
    int ek, ei, gate_err;
    if (armed) exp_decide(d, sta_addr, promisc, mcast_en, ek, ei);
    else begin ek = 0; ei = -1; end
    if (drop_at >= 0 && ei >= drop_at) begin ek = 0; ei = -1; end
    ev_cnt = 0; first_kind = 0; first_idx = -1; cur_idx = -1; gate_err = 0;
    for (int i = 0; i < pre_n; i++) bit_(1'b1, (i % 2) == 0);
    bit_(1'b1, 1'b1);
    bit_(1'b1, 1'b1);
    for (int k = 0; k < 48; k++) begin
      if (k == drop_at) break;
      cur_idx = k;
      bit_(1'b1, d[k]);
    end
    cur_idx = -1;
    if (drop_at < 0) begin
      for (int p = 0; p < paylen; p++) begin
        bit_(1'b1, 1'($urandom % 2));
        if (s_gate != (ek == 1)) gate_err++;
      end
    end
    bit_(1'b0, 1'b0);
    chk(s_gate == 1'b0, "R10", "gate after carrier loss", int'(s_gate), 0);
    idle(gap - 1);
    chk(first_kind * 100 + first_idx == ek * 100 + ei, req, "verdict kind*100+bit",
        first_kind * 100 + first_idx, ek * 100 + ei);
    chk(ev_cnt == ((ek != 0) ? 1 : 0), req, "pulse count", ev_cnt, (ek != 0) ? 1 : 0);
    chk(gate_err == 0, req, "gate errors during payload (R10)", gate_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] d;
    int sel;
    void'($urandom(32'd4242));
    both_cnt = 0;
    sta_addr = {$urandom, 16'($urandom)};
    sta_addr[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk(!acc_pulse && !rej_pulse && !pass_gate, "R1", "outputs in reset",
        int'({acc_pulse, rej_pulse, pass_gate}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!acc_pulse && !rej_pulse && !pass_gate, "R1", "outputs after reset",
        int'({acc_pulse, rej_pulse, pass_gate}), 0);

    // R2: only 95 idle bits after reset, frame must be ignored
    idle(95);
    send_frame(62, sta_addr, 8, 96, -1, 1'b0, "R2");
    // R3/R5: full preamble, matching unicast
    send_frame(62, sta_addr, 16, 96, -1, 1'b1, "R5");
    // R3: late wake-up, a single alternation before the delimiter
    send_frame(2, sta_addr, 8, 96, -1, 1'b1, "R3");
    // R6: mismatch in the middle and on the last bit
    send_frame(20, sta_addr ^ (48'd1 << 30), 12, 96, -1, 1'b1, "R6");
    send_frame(20, sta_addr ^ (48'd1 << 47), 12, 96, -1, 1'b1, "R6");
    // R7: broadcast with multicast disabled
    send_frame(30, {48{1'b1}}, 10, 96, -1, 1'b1, "R7");
    // R8: group frame, multicast off then on
    d = sta_addr | 48'h0000_0000_0001; d[9] = 1'b0;
    send_frame(30, d, 10, 96, -1, 1'b1, "R8");
    mcast_en = 1'b1;
    send_frame(30, d, 10, 96, -1, 1'b1, "R8");
    mcast_en = 1'b0;
    // R9: promiscuous accepts a mismatching unicast
    promisc = 1'b1;
    send_frame(30, sta_addr ^ 48'h20, 10, 96, -1, 1'b1, "R9");
    promisc = 1'b0;
    // R11: carrier lost in the address, then a short gap leaves the block disarmed
    send_frame(30, sta_addr, 0, 50, 20, 1'b1, "R11");
    send_frame(30, sta_addr, 8, 96, -1, 1'b0, "R11");
    send_frame(30, sta_addr, 8, 96, -1, 1'b1, "R11");
    // R12: accepted frame followed by a 95-bit gap
    send_frame(30, sta_addr, 8, 95, -1, 1'b1, "R12");
    send_frame(30, sta_addr, 8, 96, -1, 1'b0, "R12");
    send_frame(30, sta_addr, 8, 96, -1, 1'b1, "R12");
    // R4: broken alternation, then "1,1" and zeros must not start an address
    ev_cnt = 0; first_kind = 0; cur_idx = -1;
    bit_(1, 1); bit_(1, 0); bit_(1, 1); bit_(1, 0); bit_(1, 0); bit_(1, 0);
    bit_(1, 1); bit_(1, 1);
    for (int k = 0; k < 48; k++) bit_(1'b1, 1'b0);
    idle(96);
    chk(ev_cnt == 0, "R4", "pulses after broken preamble", ev_cnt, 0);
    // R4: broken alternation followed by a proper preamble resynchronises
    bit_(1, 1); bit_(1, 0); bit_(1, 0);
    send_frame(6, sta_addr, 8, 96, -1, 1'b1, "R4");

    // random frames, each after a full gap
    for (int f = 0; f < 40; f++) begin
      promisc  = ($urandom % 6) == 0;
      mcast_en = 1'($urandom % 2);
      sel = $urandom % 5;
      case (sel)
        0: d = sta_addr;
        1: d = sta_addr ^ (48'd1 << ($urandom % 47 + 1));
        2: d = {48{1'b1}};
        3: begin d = {$urandom, 16'($urandom)}; d[0] = 1'b1; end
        default: begin d = {$urandom, 16'($urandom)}; d[0] = 1'b0; end
      endcase
      send_frame(2 * (1 + $urandom % 31), d, 8 + $urandom % 24, 96 + $urandom % 20,
                 (($urandom % 8) == 0) ? int'($urandom % 48) : -1, 1'b1, "R5/R6/R8 random");
    end
    chk(both_cnt == 0, "R13", "cycles with both pulses", both_cnt, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule